// File: doc/BRIEF.md
# Binary-Weighted Pulse-Density Serializer

This block turns a stream of 32-bit words into a one-pin pulse-density signal. Every word carries six 5-bit codes. For each code the pin shows the code's bits one after another, and each bit position has its own binary-weighted hold time. The most significant code bit is held for 8 slot ticks, the next for 4, then 2, then 1 and 1. One code therefore fills a frame of exactly 16 ticks. The number of high ticks in a frame is set by the code and can be any value from 0 to 16. Unlike a counter-compare PWM, the pin may toggle several times inside one frame.

Words arrive on a valid/ready interface that acts like a transmit FIFO with automatic refill. The block takes a new word on the same clock edge that ends the last slot of the previous word, so frames run back to back. When no word is waiting, the block stalls. While stalled it holds the pin at its last value and flags underrun, and it restarts cleanly at the beginning of the next word. An integer clock-enable divider sets the length of one slot tick in clock cycles.

The control is a three-state machine. IDLE is the state after reset, before any word has been taken. RUN is the state while slots are being played. STALL is the state when a word ran out with no successor waiting. The transitions are: IDLE to RUN when a word is taken on a tick; RUN to STALL when the last slot ends on a tick and no word is valid; STALL to RUN when a word is taken on a tick; and any state to IDLE when reset is applied.

Top module: `pds_serializer`

## Requirements
- R1: Within a code the pin shows the code bits MSB first. The bit held for 8 ticks comes first, then bits held for 4, 2, 1 and 1 ticks, with every hold measured in slot ticks.
- R2: A code frame lasts 16 ticks. For a code c[4:0], the pin is high for 8*c[4] + 4*c[3] + 2*c[2] + c[1] + c[0] ticks of that frame, a value from 0 to 16.
- R3: The first code of a word comes from word bits [31:27], the following codes from each next lower 5-bit field, and the sixth code from bits [6:2]. Word bits [1:0] have no effect on the pin.
- R4: The next word is taken on the clock edge that ends the last slot of the current word, so the output has no gap. word_ready is high only in that accepting cycle, and only while word_valid is high.
- R5: Code 10000 gives 8 high ticks followed by 8 low ticks. Code 01111 gives 8 low ticks followed by 8 high ticks. Code 00000 keeps the pin low for all 16 ticks.
- R6: pin_out changes only on a clock edge that ends a cycle in which the slot tick was active.
- R7: When a word runs out and none is valid, pin_out holds its last value and underrun is high in every stalled cycle. The next word is played from its first code. The idle state after reset, before any word, does not raise underrun.
- R8: A slot tick occurs once every div_val clock cycles. A div_val of 0 behaves like 1, which runs the block at the full clock rate.
- R9: A synchronous active-low reset drives pin_out and underrun low and discards a partly played word. The next word taken after reset starts from its first code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_val | input | 16 | Clock cycles per slot tick (0 acts as 1) |
| word_data | input | 32 | Word holding six 5-bit codes in bits [31:2] |
| word_valid | input | 1 | word_data holds a word to be taken |
| word_ready | output | 1 | Word taken in this cycle |
| pin_out | output | 1 | Registered pulse-density output |
| underrun | output | 1 | High in each cycle the serializer is stalled for lack of a word |

## Verification
Most faults in the slot counter or the bit counter show up on pin_out within a single 16-tick frame. A wrong hold preset moves a transition, and a wrong bit count shifts every later code of the word, so the high-tick total of a frame no longer matches the weighted code value. A fault in the acceptance decision shows one cycle early or late on word_ready, or as an underrun pulse between two words that should be gapless. A fault in the stall state shows in the first stalled cycle, either as a pin change or as a missing underrun.

// File: rtl/pds_pkg.sv
package pds_pkg;

    // Serializer control states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // after reset, no word taken yet
        ST_RUN   = 2'd1,   // playing slots
        ST_STALL = 2'd2    // word exhausted, none waiting
    } pds_state_t;

endpackage

// File: rtl/pds_tick_gen.sv
module pds_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_eff;

    assign div_eff = (div_val == '0) ? DIV_W'(1) : div_val;
    assign tick    = (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= div_eff - 1'b1;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // R8: with a divide above one, a tick is never followed directly by another
    a_r8_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_eff > DIV_W'(1)) |=> !tick);

endmodule

// File: rtl/pds_slot_ctrl.sv
module pds_slot_ctrl
    import pds_pkg::*;
#(
    parameter int WORD_W         = 32,
    parameter int CODE_BITS      = 5,
    parameter int CODES_PER_WORD = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [WORD_W-1:0] word_data,
    input  logic              word_valid,
    output logic              word_ready,
    output logic              pin_out,
    output logic              underrun
);

    localparam int USED_BITS = CODE_BITS * CODES_PER_WORD;
    localparam int CNT_W     = $clog2(USED_BITS + 1);
    localparam int SLOT_W    = $clog2(CODE_BITS);
    localparam int HOLD_W    = CODE_BITS - 1;

    pds_state_t        state, state_n;
    logic [WORD_W-1:0] sreg;
    logic [CNT_W-1:0]  bits_left;
    logic [SLOT_W-1:0] slot;
    logic [HOLD_W-1:0] hold;
    logic              need_word;
    logic              take;

    // Hold preset (weight minus one) for a given slot position
    function automatic logic [HOLD_W-1:0] hold_preset(input logic [SLOT_W-1:0] s);
        int w;
        if (int'(s) < CODE_BITS - 1) begin
            w = (1 << (CODE_BITS - 2 - int'(s))) - 1;
        end else begin
            w = 0;
        end
        return w[HOLD_W-1:0];
    endfunction

    assign need_word = (state != ST_RUN) || (hold == '0 && bits_left == '0);
    assign take      = tick && need_word && word_valid;

    // Next state and outputs
    always_comb begin
        state_n    = state;
        word_ready = take;
        underrun   = (state == ST_STALL);
        unique case (state)
            ST_IDLE:  if (take) state_n = ST_RUN;
            ST_STALL: if (take) state_n = ST_RUN;
            ST_RUN:   if (tick && need_word && !word_valid) state_n = ST_STALL;
            default:  state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Slot datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_out   <= 1'b0;
            sreg      <= '0;
            bits_left <= '0;
            slot      <= '0;
            hold      <= '0;
        end else if (take) begin
            pin_out   <= word_data[WORD_W-1];
            sreg      <= {word_data[WORD_W-2:0], 1'b0};
            bits_left <= CNT_W'(USED_BITS - 1);
            slot      <= SLOT_W'(1);
            hold      <= hold_preset('0);
        end else if (state == ST_RUN && tick) begin
            if (hold != '0) begin
                hold <= hold - 1'b1;
            end else if (bits_left != '0) begin
                pin_out   <= sreg[WORD_W-1];
                sreg      <= {sreg[WORD_W-2:0], 1'b0};
                bits_left <= bits_left - 1'b1;
                hold      <= hold_preset(slot);
                slot      <= (slot == SLOT_W'(CODE_BITS - 1)) ? '0 : slot + 1'b1;
            end
        end
    end

    // R4: a word is only taken when offered
    a_r4_ready_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready |-> word_valid);

    // R4: acceptance happens only on a slot tick
    a_r4_ready_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready |-> tick);

    // R7: pin frozen while stalled
    a_r7_pin_held_stall: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> $stable(pin_out));

endmodule

// File: rtl/pds_serializer.sv
module pds_serializer #(
    parameter int WORD_W         = 32,
    parameter int CODE_BITS      = 5,
    parameter int CODES_PER_WORD = 6,
    parameter int DIV_W          = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_val,
    input  logic [WORD_W-1:0] word_data,
    input  logic              word_valid,
    output logic              word_ready,
    output logic              pin_out,
    output logic              underrun
);

    logic tick;

    pds_tick_gen #(
        .DIV_W(DIV_W)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_val(div_val),
        .tick   (tick)
    );

    pds_slot_ctrl #(
        .WORD_W        (WORD_W),
        .CODE_BITS     (CODE_BITS),
        .CODES_PER_WORD(CODES_PER_WORD)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .word_data (word_data),
        .word_valid(word_valid),
        .word_ready(word_ready),
        .pin_out   (pin_out),
        .underrun  (underrun)
    );

    // R6: pin moves only after a ticked cycle
    a_r6_pin_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out != $past(pin_out)) |-> $past(tick));

    // R9: outputs cleared after any reset cycle
    logic rst_was_low;
    always_ff @(posedge clk) rst_was_low <= !rst_n;

    always @(negedge clk) begin
        if (rst_was_low) begin
            a_r9_reset_clears: assert (!pin_out && !underrun);
        end
    end

endmodule

// File: tb/pds_serializer_tb.sv
module pds_serializer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    localparam logic [31:0] VEC_WORDS [NVEC] = '{
        32'h8421_0840, 32'h7BDE_F7BF, 32'h0000_0003, 32'hFFFF_FFFF,
        32'h1234_5678, 32'hA5A5_A5A5, 32'hFFFF_FFFC, 32'h0C63_18C6
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] div_val = 16'd1;
    logic [31:0] word_data = '0;
    logic        word_valid = 1'b0;
    logic        word_ready;
    logic        pin_out;
    logic        underrun;

    int          total = 0;
    int          bad = 0;
    logic [15:0] frame0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pds_serializer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_val   (div_val),
        .word_data (word_data),
        .word_valid(word_valid),
        .word_ready(word_ready),
        .pin_out   (pin_out),
        .underrun  (underrun)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int weighted(input logic [4:0] c);
        return 8*c[4] + 4*c[3] + 2*c[2] + c[1] + c[0];
    endfunction

    // Offer a word and wait for it to be taken; returns after the accepting edge
    task automatic start_word(input logic [31:0] w);
        bit got = 0;
        word_data  = w;
        word_valid = 1'b1;
        for (int i = 0; i < 200 && !got; i++) begin
            @(negedge clk);
            got = word_ready;
        end
        check(got, "R4 take", int'(got), 1);
        @(posedge clk);
        #1;
    endtask

    // Play a word already taken; offer the next one meanwhile
    task automatic play_word(input logic [31:0] w, input int div,
                             input logic [31:0] nxt, input bit have_nxt);
        int tot = 96 * div;
        int e_pin = 0, e_rdy = 0, e_un = 0, hi = 0;
        word_data  = nxt;
        word_valid = have_nxt;
        for (int k = 0; k < tot; k++) begin
            int t = k / div;
            int code = t / 16;
            int off = t % 16;
            int sl = (off < 8) ? 0 : (off < 12) ? 1 : (off < 14) ? 2 : (off == 14) ? 3 : 4;
            logic exp_pin;
            logic exp_rdy;
            @(negedge clk);
            exp_pin = w[31 - code*5 - sl];
            exp_rdy = have_nxt && (k == tot - 1);
            if (pin_out !== exp_pin) e_pin++;
            if (word_ready !== exp_rdy) e_rdy++;
            if (underrun !== 1'b0) e_un++;
            if (k < 16) frame0[15-k] = pin_out;
            hi += int'(pin_out);
            if ((k + 1) % (16 * div) == 0) begin
                int ex = div * weighted(w[31 - code*5 -: 5]);
                check(hi == ex, "R2 frame high count", hi, ex);
                hi = 0;
            end
        end
        // R1, R3, R6: exact per-cycle pattern, bits [1:0] ignored
        check(e_pin == 0, "R1,R3 pin pattern", e_pin, 0);
        check(e_rdy == 0, "R4 ready timing", e_rdy, 0);
        check(e_un == 0, "R7 no underrun while fed", e_un, 0);
        @(posedge clk);
        #1;
    endtask

    initial begin
        // Reset state
        repeat (3) @(negedge clk);
        check(pin_out == 1'b0 && underrun == 1'b0 && word_ready == 1'b0,
              "R9 reset outputs", {pin_out, underrun, word_ready}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(underrun == 1'b0 && pin_out == 1'b0, "R7 idle is not underrun",
              {pin_out, underrun}, 0);

        // Table walk, gapless at full rate
        start_word(VEC_WORDS[0]);
        for (int i = 0; i < NVEC; i++) begin
            play_word(VEC_WORDS[i], 1, (i < NVEC-1) ? VEC_WORDS[i+1] : 32'h0, i < NVEC-1);
        end

        // Stall after last word: pin held at bit 2 of last word
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(underrun == 1'b1, "R7 underrun flagged", underrun, 1);
            check(pin_out == VEC_WORDS[NVEC-1][2], "R7 pin held", pin_out, VEC_WORDS[NVEC-1][2]);
        end

        // Exact patterns for the named codes
        start_word(32'h8421_0840);
        play_word(32'h8421_0840, 1, 32'h7BDE_F7BC, 1);
        check(frame0 == 16'hFF00, "R5 code 10000", frame0, 16'hFF00);
        play_word(32'h7BDE_F7BC, 1, 32'h0, 1);
        check(frame0 == 16'h00FF, "R5 code 01111", frame0, 16'h00FF);
        play_word(32'h0, 1, 32'h0, 0);
        check(frame0 == 16'h0000, "R5 code 00000", frame0, 16'h0000);

        // Resume after stall at start of new word
        repeat (4) @(negedge clk);
        start_word(32'hA5A5_A5A5);
        play_word(32'hA5A5_A5A5, 1, 32'h0, 0);

        // Divider of three
        div_val = 16'd3;
        start_word(32'h8421_0843);
        play_word(32'h8421_0843, 3, 32'h5AF0_3C99, 1);
        play_word(32'h5AF0_3C99, 3, 32'h0, 0);

        // Divider of zero behaves as one (R8)
        div_val = 16'd0;
        start_word(32'hDEAD_BEEF);
        play_word(32'hDEAD_BEEF, 1, 32'h0, 0);
        div_val = 16'd1;

        // Reset in mid-word discards it
        start_word(32'hFFFF_FFFF);
        word_valid = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(pin_out == 1'b0 && underrun == 1'b0 && word_ready == 1'b0,
              "R9 mid-word reset", {pin_out, underrun, word_ready}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(pin_out == 1'b0 && underrun == 1'b0, "R9 word discarded",
              {pin_out, underrun}, 0);
        start_word(32'h8421_0840);
        play_word(32'h8421_0840, 1, 32'h0, 0);
        check(frame0 == 16'hFF00, "R9 fresh start after reset", frame0, 16'hFF00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule